// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a byte address in tiled address space. The pixel element size is 8, 16 or 32 bits. The address also carries the element size and the view orientation (rotation and mirroring) in its upper bits, so that the memory behind the address can present the same buffer in any of eight views.

Rotation and mirroring work only on the coordinates. Each axis can be inverted against its own maximum, and the major axis can be swapped. The element size sets how many bits each coordinate has. It also sets how far the linear offset is shifted up, so that every element stays aligned to its own size.

The row stride of the chosen view is returned with the address. Each request is taken in through a valid/ready handshake, and the result is held in a single output register stage.

Top module: `tva_addr_gen`

## Requirements
- R1: Format codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements. The code is placed in address bits [28:27]. Code 3 is not a valid format and is reported as an error.
- R2: The 3-bit orientation code is placed unchanged in address bits [31:29].
- R3: The x coordinate may use 14 − xs bits and the y coordinate 13 − ys bits, where (xs, ys) is (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. A coordinate above its limit, or format code 3, gives out_err = 1 with out_addr = 0 and out_stride = 0.
- R4: Orientation bit 1 replaces x by (x_limit − x). Orientation bit 0 replaces y by (y_limit − y).
- R5: With orientation bit 2 clear, the linear offset is y·2^(x bits) + x. With bit 2 set, it is x·2^(y bits) + y.
- R6: The linear offset is shifted left by xs + ys and then fills address bits [26:0].
- R7: out_stride is 2^(14 + ys) when orientation bit 2 is clear, and 2^(13 + xs) when it is set.
- R8: in_ready is high exactly when the output stage is empty or out_ready is high. An accepted request appears on the outputs after the next clock edge. While out_valid is high and out_ready is low, all outputs hold.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_fmt | input | 2 | Element format code |
| in_orient | input | 3 | View orientation code |
| in_x | input | COORD_W (16) | Pixel x coordinate |
| in_y | input | COORD_W (16) | Pixel y coordinate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Tiled byte address |
| out_err | output | 1 | Coordinate or format rejected |
| out_stride | output | 16 | Row stride of the view in bytes |

## Verification
The bench uses the default parameters: 14 width bits, 13 height bits and 16-bit coordinate inputs, which give a 32-bit address. The 16-bit inputs can carry values just past every format's coordinate limit. This reaches the exact boundary between accepted and rejected coordinates in all three formats. All eight orientations are driven at the container corners. A random stall pattern on out_ready exercises the hold and back-pressure behaviour.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_E8  = 2'd0,
    FMT_E16 = 2'd1,
    FMT_E32 = 2'd2,
    FMT_BAD = 2'd3
  } tva_fmt_e;

  function automatic int fmt_xshift(tva_fmt_e f);
    return (f == FMT_E32) ? 1 : 0;
  endfunction

  function automatic int fmt_yshift(tva_fmt_e f);
    return (f == FMT_E8) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tva_coord_map.sv
module tva_coord_map
  import tva_pkg::*;
#(
  parameter int W_BITS  = 14,
  parameter int H_BITS  = 13,
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tva_fmt_e           fmt,
  input  logic [2:0]         orient,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic               err,
  output logic [W_BITS-1:0]  xi,
  output logic [H_BITS-1:0]  yi
);
  logic [W_BITS-1:0] x_lim;
  logic [H_BITS-1:0] y_lim;
  logic              x_over;
  logic              y_over;

  always_comb begin
    x_lim  = {W_BITS{1'b1}} >> fmt_xshift(fmt);
    y_lim  = {H_BITS{1'b1}} >> fmt_yshift(fmt);
    x_over = x > COORD_W'(x_lim);
    y_over = y > COORD_W'(y_lim);
    err    = x_over || y_over || (fmt == FMT_BAD);
    xi     = orient[1] ? (x_lim - x[W_BITS-1:0]) : x[W_BITS-1:0];
    yi     = orient[0] ? (y_lim - y[H_BITS-1:0]) : y[H_BITS-1:0];
  end

  AST_MAPPED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (xi <= x_lim) && (yi <= y_lim)); // R4
endmodule

// File: rtl/tva_offset_pack.sv
module tva_offset_pack
  import tva_pkg::*;
#(
  parameter int W_BITS   = 14,
  parameter int H_BITS   = 13,
  parameter int STRIDE_W = 16,
  localparam int OFF_W   = W_BITS + H_BITS
) (
  input  tva_fmt_e            fmt,
  input  logic                swap,
  input  logic [W_BITS-1:0]   xi,
  input  logic [H_BITS-1:0]   yi,
  output logic [OFF_W-1:0]    offset,
  output logic [STRIDE_W-1:0] stride
);
  logic [OFF_W-1:0] lin;
  int               xs;
  int               ys;

  always_comb begin
    xs = fmt_xshift(fmt);
    ys = fmt_yshift(fmt);
    if (swap) begin
      lin    = (OFF_W'(xi) << (H_BITS - ys)) + OFF_W'(yi);
      stride = STRIDE_W'(1) << (H_BITS + xs);
    end else begin
      lin    = (OFF_W'(yi) << (W_BITS - xs)) + OFF_W'(xi);
      stride = STRIDE_W'(1) << (W_BITS + ys);
    end
    offset = lin << (xs + ys);
  end
endmodule

// File: rtl/tva_out_stage.sv
module tva_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              valid_q;
  logic              valid_d;
  logic              load_en;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load_en  = in_valid && in_ready;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
endmodule

// File: rtl/tva_addr_gen.sv
module tva_addr_gen
  import tva_pkg::*;
#(
  parameter int W_BITS    = 14,
  parameter int H_BITS    = 13,
  parameter int COORD_W   = 16,
  localparam int OFF_W    = W_BITS + H_BITS,
  localparam int ADDR_W   = OFF_W + 5,
  localparam int STRIDE_W = ((W_BITS > H_BITS) ? W_BITS : H_BITS) + 2,
  localparam int PAY_W    = ADDR_W + 1 + STRIDE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_fmt,
  input  logic [2:0]          in_orient,
  input  logic [COORD_W-1:0]  in_x,
  input  logic [COORD_W-1:0]  in_y,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                out_err,
  output logic [STRIDE_W-1:0] out_stride
);
  tva_fmt_e            fmt;
  logic                err;
  logic [W_BITS-1:0]   xi;
  logic [H_BITS-1:0]   yi;
  logic [OFF_W-1:0]    offset;
  logic [STRIDE_W-1:0] stride;
  logic [ADDR_W-1:0]   addr_d;
  logic [STRIDE_W-1:0] stride_d;
  logic [PAY_W-1:0]    pay_in;
  logic [PAY_W-1:0]    pay_out;

  assign fmt = tva_fmt_e'(in_fmt);

  tva_coord_map #(.W_BITS(W_BITS), .H_BITS(H_BITS), .COORD_W(COORD_W)) coord_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .orient(in_orient),
    .x(in_x), .y(in_y), .err(err), .xi(xi), .yi(yi)
  );

  tva_offset_pack #(.W_BITS(W_BITS), .H_BITS(H_BITS), .STRIDE_W(STRIDE_W)) pack_i (
    .fmt(fmt), .swap(in_orient[2]), .xi(xi), .yi(yi),
    .offset(offset), .stride(stride)
  );

  always_comb begin
    if (err) begin
      addr_d   = '0;
      stride_d = '0;
    end else begin
      addr_d   = {in_orient, in_fmt, offset};
      stride_d = stride;
    end
    pay_in = {addr_d, err, stride_d};
  end

  tva_out_stage #(.DATA_W(PAY_W)) out_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(pay_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(pay_out)
  );

  assign {out_addr, out_err, out_stride} = pay_out;

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_addr == '0) && (out_stride == '0)); // R3
  AST_STRIDE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> $countones(out_stride) == 1); // R7
  AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_addr[OFF_W+1:OFF_W] != 2'd3); // R1
  AST_ALIGN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && (out_addr[OFF_W+1:OFF_W] == 2'd2) |-> out_addr[1:0] == 2'b00); // R6
endmodule

// File: tb/tva_addr_gen_tb_top.sv
module tva_addr_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_fmt;
  logic [2:0]  in_orient;
  logic [15:0] in_x;
  logic [15:0] in_y;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic        out_err;
  logic [15:0] out_stride;

  int checks;
  int errors;
  int pushed;
  int popped;
  bit stall_mode;
  logic [48:0] exp_q[$];

  tva_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_err(out_err), .out_stride(out_stride)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [48:0] model(int f, int o, int x, int y);
    int xs, ys, xb, yb, xl, yl, xv, yv;
    longint off, addr, str;
    xs = (f == 2) ? 1 : 0;
    ys = (f == 0) ? 0 : 1;
    xb = 14 - xs;
    yb = 13 - ys;
    xl = (1 << xb) - 1;
    yl = (1 << yb) - 1;
    if (f == 3 || x > xl || y > yl) return {32'd0, 1'b1, 16'd0};
    xv = ((o & 2) != 0) ? xl - x : x;
    yv = ((o & 1) != 0) ? yl - y : y;
    if ((o & 4) != 0) begin
      off = (longint'(xv) << yb) + yv;
      str = longint'(1) << (13 + xs);
    end else begin
      off = (longint'(yv) << xb) + xv;
      str = longint'(1) << (14 + ys);
    end
    addr = (longint'(o) << 29) | (longint'(f) << 27) | (off << (xs + ys));
    return {addr[31:0], 1'b0, str[15:0]};
  endfunction

  task automatic check(string req, logic [48:0] act, logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual addr=%h err=%b stride=%h expected addr=%h err=%b stride=%h",
               req, act[48:17], act[16], act[15:0], exp[48:17], exp[16], exp[15:0]);
    end
  endtask

  task automatic send(string req, int f, int o, int x, int y);
    @(negedge clk);
    in_valid  = 1'b1;
    in_fmt    = f[1:0];
    in_orient = o[2:0];
    in_x      = x[15:0];
    in_y      = y[15:0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(model(f, o, x, y));
    pushed++;
    if (req.len() == 0) pushed = pushed;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // ready pattern changes away from both edges used for sampling
  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  // monitor: pop and compare at every transfer
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R8 in_ready actual %b expected %b", in_ready, !out_valid || out_ready);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 unexpected output actual addr=%h expected none", out_addr);
        end else begin
          check("R1 R2 R3 R4 R5 R6 R7 result", {out_addr, out_err, out_stride}, exp_q.pop_front());
          popped++;
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; pushed = 0; popped = 0;
    stall_mode = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = 2'd0; in_orient = 3'd0;
    in_x = 16'd0; in_y = 16'd0; out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    // R1 R2 R4 R5 R6 R7: every format and orientation at corners and interior
    for (int f = 0; f < 3; f++) begin
      for (int o = 0; o < 8; o++) begin
        send("R2", f, o, 0, 0);
        send("R4", f, o, 5, 3);
        send("R5", f, o, (f == 2) ? 8191 : 16383, (f == 0) ? 8191 : 4095);
      end
    end
    idle();
    // R3: limits and one past them per format, plus the illegal format
    send("R3", 0, 0, 16383, 8191);
    send("R3", 0, 0, 16384, 0);
    send("R3", 0, 0, 0, 8192);
    send("R3", 1, 0, 16383, 4095);
    send("R3", 1, 0, 16383, 4096);
    send("R3", 2, 0, 8191, 4095);
    send("R3", 2, 0, 8192, 4095);
    send("R3", 2, 7, 65535, 65535);
    send("R1", 3, 0, 0, 0);
    send("R1", 3, 5, 1, 1);
    idle();
    repeat (3) @(posedge clk);
    // R8: random traffic under back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send("R8", $urandom % 4, $urandom % 8, $urandom % 17000, $urandom % 8400);
      if ($urandom % 4 == 0) idle();
    end
    idle();
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (popped != pushed || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 count actual %0d expected %0d", popped, pushed);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule